// File: doc/BRIEF.md
# Write-Once Configuration Register File

This block is the identification and configuration store of a controller that manages two device bays. An upstream bus interface reaches it through a byte-wide port covering offsets 0x00 to 0x0F. Multi-byte registers are little-endian, so the least significant byte sits at the register's lowest offset. The block holds two fixed identification registers: a 16-bit vendor number and an 8-bit revision code. It also holds three configuration registers that start-up firmware fills in: two 16-bit subsystem identifiers and a capabilities byte.

Each configuration byte accepts exactly one write after reset and ignores every later write without error. Firmware therefore sets the platform description once, and nothing written afterwards can change it. The capabilities field stores a bay count and a flag that says whether a physical security lock is fitted. A bay count that the controller cannot support is replaced by the largest legal count. The locked values are driven onto dedicated outputs for the rest of the controller. Only the synchronous active-low reset clears the locks and restores the reset values. That reset input is shared by power-on reset and the external reset pin.

Top module: `cfgreg_file`

## Requirements
- R1: In the first cycle after reset the outputs hold their reset values: `ssvid` = 0, `ssid` = 0, `bay_count` = 2, `sec_lock_present` = 0 and `rdata` = 0.
- R2: When `rd_en` is high at a rising edge, `rdata` shows the byte at `addr` from that edge onward. While `rd_en` is low, `rdata` keeps its value.
- R3: Offsets 0x00 to 0x03 read 0x60, 0x12, 0x00 and 0x00, which is the 32-bit value 0x0000_1260. Writes to these offsets have no effect.
- R4: Offset 0x04 reads the revision code (default 0x01), and offsets 0x05 to 0x07 read zero. Writes to all four offsets have no effect.
- R5: Offsets 0x08 and 0x09 hold the low and high bytes of `ssvid`. Offsets 0x0A and 0x0B hold the low and high bytes of `ssid`. The first write to a byte stores it on the output at the same edge, and the byte reads back from then on.
- R6: After its first write, each identifier byte ignores all further writes. The lock of one byte does not affect the other three bytes.
- R7: The first write to offset 0x0C stores bit 4 as `sec_lock_present` and bits 3:0 as the bay count. The whole field then ignores further writes. Offset 0x0C reads back as {3'b000, flag, count}, so written bits 7:5 are discarded.
- R8: The bay count stores a written value of 0, 1 or 2 unchanged. Any written value from 3 to 15 is stored as 2.
- R9: Writes to offsets 0x0D to 0x0F have no effect, and these offsets read zero.
- R10: Reset clears every lock and restores the reset values, so that each configuration byte can again be written once.
- R11: A read does not set a lock or change any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on or external pin) |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 4 | Byte offset 0x00 to 0x0F |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ssvid | output | 16 | Locked subsystem vendor identifier |
| ssid | output | 16 | Locked subsystem identifier |
| bay_count | output | 4 | Locked bay count, at most 2 |
| sec_lock_present | output | 1 | Locked security-lock-present flag |

## Verification
A write takes effect on the configuration outputs at the rising edge that samples it, so the bench checks those outputs at the falling edge that follows. A read is registered once: the bench raises `rd_en` at a falling edge, lowers it at the next falling edge, and compares `rdata` at that point, which is after the single capture edge. Every ignored write is checked the same way, one falling edge after it, against a bench model of bytes and locks. Reset is released at a falling edge, and the reset values are checked at the next falling edge.

// File: rtl/cfgreg_pkg.sv
// Shared constants and helpers for the write-once configuration register file.
// Assumes a 4-bit byte offset space; offsets above 0x0F do not exist.
package cfgreg_pkg;
    localparam int ADDR_W = 4;
    localparam int BAY_W  = 4;
    localparam int CAPS_W = BAY_W + 1;
    localparam int ID_BYTES = 4;

    localparam logic [ADDR_W-1:0] OFS_VENDOR = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_REV    = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_IDS    = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_CAPS   = 4'hC;

    // Replace an unsupported bay count with the largest legal count.
    function automatic logic [BAY_W-1:0] legal_bays(input logic [BAY_W-1:0] v,
                                                    input logic [BAY_W-1:0] max_bays);
        return (v > max_bays) ? max_bays : v;
    endfunction
endpackage

// File: rtl/cfgreg_wo_cell.sv
// One write-once field: the first strobed write is stored, and the field then locks.
// Assumes rst_n is synchronous and active low; only reset clears the lock.
module cfgreg_wo_cell #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);
    logic locked;

    // Store the first write after reset and refuse all later writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= RST_VAL;
            locked <= 1'b0;
        end else if (we && !locked) begin
            q      <= wd;
            locked <= 1'b1;
        end
    end
endmodule

// File: rtl/cfgreg_caps.sv
// Capabilities field: the bay count and the security flag lock together on one write.
// Assumes the caller decodes the offset; an unsupported bay count is stored as MAX_BAYS.
module cfgreg_caps
    import cfgreg_pkg::*;
#(
    parameter int MAX_BAYS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       wd,
    output logic [BAY_W-1:0] bays,
    output logic             sec
);
    localparam logic [BAY_W-1:0] MAXB = BAY_W'(MAX_BAYS);
    logic [CAPS_W-1:0] field_d, field_q;

    // Form the legal field value from the written byte.
    always_comb field_d = {wd[BAY_W], legal_bays(wd[BAY_W-1:0], MAXB)};

    cfgreg_wo_cell #(.W(CAPS_W), .RST_VAL({1'b0, MAXB})) i_field (
        .clk(clk), .rst_n(rst_n), .we(we), .wd(field_d), .q(field_q)
    );

    // Split the locked field into its two outputs.
    always_comb begin
        bays = field_q[BAY_W-1:0];
        sec  = field_q[BAY_W];
    end
endmodule

// File: rtl/cfgreg_rdmux.sv
// Read decode: selects one byte of the register file by offset.
// Purely combinational; unmapped offsets return zero.
module cfgreg_rdmux
    import cfgreg_pkg::*;
#(
    parameter logic [15:0] VENDOR_NUM = 16'h1260,
    parameter logic [7:0]  REV_CODE   = 8'h01
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [8*ID_BYTES-1:0] id_bytes,
    input  logic [CAPS_W-1:0]   caps,
    output logic [7:0]          byte_out
);
    // Map each offset to its byte; everything else reads zero.
    always_comb begin
        byte_out = 8'h00;
        case (addr)
            OFS_VENDOR:            byte_out = VENDOR_NUM[7:0];
            OFS_VENDOR + 4'd1:     byte_out = VENDOR_NUM[15:8];
            OFS_REV:               byte_out = REV_CODE;
            OFS_IDS:               byte_out = id_bytes[7:0];
            OFS_IDS + 4'd1:        byte_out = id_bytes[15:8];
            OFS_IDS + 4'd2:        byte_out = id_bytes[23:16];
            OFS_IDS + 4'd3:        byte_out = id_bytes[31:24];
            OFS_CAPS:              byte_out = {{(8-CAPS_W){1'b0}}, caps};
            default:               byte_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfgreg_file.sv
// Top of the write-once configuration register file: byte port, locked cells, read register.
// Assumes one access per cycle from the upstream bus interface; a read returns pre-write data.
module cfgreg_file
    import cfgreg_pkg::*;
#(
    parameter logic [15:0] VENDOR_NUM = 16'h1260,
    parameter logic [7:0]  REV_CODE   = 8'h01,
    parameter int          MAX_BAYS   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [15:0]      ssvid,
    output logic [15:0]      ssid,
    output logic [3:0]       bay_count,
    output logic             sec_lock_present
);
    logic [8*ID_BYTES-1:0] id_bytes;
    logic [7:0]            rd_byte;

    // One write-once cell per identifier byte, little-endian from OFS_IDS.
    for (genvar i = 0; i < ID_BYTES; i++) begin : g_id
        logic sel;
        always_comb sel = wr_en && (addr == OFS_IDS + ADDR_W'(i));
        cfgreg_wo_cell #(.W(8), .RST_VAL(8'h00)) i_byte (
            .clk(clk), .rst_n(rst_n), .we(sel), .wd(wdata),
            .q(id_bytes[8*i +: 8])
        );
    end

    cfgreg_caps #(.MAX_BAYS(MAX_BAYS)) i_caps (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && (addr == OFS_CAPS)), .wd(wdata),
        .bays(bay_count), .sec(sec_lock_present)
    );

    cfgreg_rdmux #(.VENDOR_NUM(VENDOR_NUM), .REV_CODE(REV_CODE)) i_rdmux (
        .addr(addr), .id_bytes(id_bytes),
        .caps({sec_lock_present, bay_count}), .byte_out(rd_byte)
    );

    // Register the selected byte on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_byte;
    end

    // Drive the locked identifiers to the rest of the controller.
    always_comb begin
        ssvid = id_bytes[15:0];
        ssid  = id_bytes[31:16];
    end
endmodule

// File: rtl/cfgreg_file_chk.sv
// Assertion checker for cfgreg_file, bound to every instance. It tracks which bytes
// have been written since reset, independently of the design's own lock flags.
module cfgreg_file_chk #(
    parameter int MAX_BAYS = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [3:0]  addr,
    input logic [4:0]  wdata_lo,
    input logic [7:0]  rdata,
    input logic [15:0] ssvid,
    input logic [15:0] ssid,
    input logic [3:0]  bay_count,
    input logic        sec_lock_present
);
    logic [3:0] seen_id;
    logic       seen_caps;
    logic [31:0] ids;

    // Remember which configuration bytes have already taken their write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_id   <= '0;
            seen_caps <= 1'b0;
        end else if (wr_en) begin
            if (addr[3:2] == 2'b10) seen_id[addr[1:0]] <= 1'b1;
            if (addr == 4'hC)       seen_caps <= 1'b1;
        end
    end

    always_comb ids = {ssid, ssvid};

    for (genvar i = 0; i < 4; i++) begin : g_lock
        AST_ID_BYTE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            seen_id[i] |=> $stable(ids[8*i +: 8])); // R6
    end

    AST_CAPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        seen_caps |=> ($stable(bay_count) && $stable(sec_lock_present))); // R7

    AST_BAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bay_count <= 4'(MAX_BAYS)); // R8

    AST_CAPS_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'hC && !seen_caps) |=>
        (sec_lock_present == $past(wdata_lo[4]) &&
         ($past(wdata_lo[3:0]) > 4'(MAX_BAYS) ? bay_count == 4'(MAX_BAYS)
                                              : bay_count == $past(wdata_lo[3:0])))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr inside {4'h2, 4'h3, 4'h5, 4'h6, 4'h7, 4'hD, 4'hE, 4'hF}))
        |=> rdata == 8'h00); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R2

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ssvid == 16'h0 && ssid == 16'h0 && !sec_lock_present &&
                          bay_count == 4'(MAX_BAYS) && rdata == 8'h00)); // R10
endmodule

bind cfgreg_file cfgreg_file_chk #(.MAX_BAYS(MAX_BAYS)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata_lo(wdata[4:0]), .rdata(rdata), .ssvid(ssvid), .ssid(ssid),
    .bay_count(bay_count), .sec_lock_present(sec_lock_present)
);

// File: tb/test_cfgreg_file.sv
// Self-checking bench: sweeps all addresses, every capabilities value and the lock
// behaviour of each byte, against a model of stored bytes and locks.
module test_cfgreg_file;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [15:0] ssvid, ssid;
    logic [3:0] bay_count;
    logic sec_lock_present;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] m_id [4];
    logic [3:0] m_idlk;
    logic [4:0] m_caps;
    logic       m_capslk;

    always #2.5 clk = ~clk;

    cfgreg_file i_cfgreg_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ssvid(ssvid), .ssid(ssid),
        .bay_count(bay_count), .sec_lock_present(sec_lock_present)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return 8'h60;
            4'h1: return 8'h12;
            4'h4: return 8'h01;
            4'h8, 4'h9, 4'hA, 4'hB: return m_id[a[1:0]];
            4'hC: return {3'b000, m_caps};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_id[i] = 8'h00;
        m_idlk = '0;
        m_caps = 5'b0_0010;
        m_capslk = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
        if (a[3:2] == 2'b10 && !m_idlk[a[1:0]]) begin
            m_id[a[1:0]] = d; m_idlk[a[1:0]] = 1'b1;
        end
        if (a == 4'hC && !m_capslk) begin
            m_caps = {d[4], (d[3:0] > 4'd2) ? 4'd2 : d[3:0]};
            m_capslk = 1'b1;
        end
    endtask

    task automatic rd_chk(input logic [3:0] a, input string req);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        chk(req, {24'h0, rdata}, {24'h0, exp_rd(a)});
    endtask

    task automatic chk_outputs(input string req);
        chk(req, {16'h0, ssvid}, {16'h0, m_id[1], m_id[0]});
        chk(req, {16'h0, ssid},  {16'h0, m_id[3], m_id[2]});
        chk(req, {27'h0, sec_lock_present, bay_count}, {27'h0, m_caps});
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 16; a++) rd_chk(4'(a), req);
    endtask

    initial begin : watchdog
        #500000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        model_reset();
        do_reset();
        // R1: reset values on every output
        chk_outputs("R1");
        chk("R1 rdata", {24'h0, rdata}, 32'h0);

        // R2 R3 R4 R9: full read sweep of fixed and unmapped bytes
        read_all("R3/R4/R9 read sweep");

        // R2: rdata holds while rd_en low, even with addr changing
        rd_chk(4'h1, "R2");
        @(negedge clk); addr = 4'h0;
        @(negedge clk);
        chk("R2 hold", {24'h0, rdata}, 32'h12);

        // R11: repeated reads do not lock; the first write still lands
        for (int k = 0; k < 4; k++) rd_chk(4'h8, "R11 read");
        wr(4'h8, 8'h3C);
        chk("R11 write after reads", {16'h0, ssvid}, 32'h3C);

        // R3 R4 R9: writes to read-only and unmapped offsets have no effect
        for (int a = 0; a < 8; a++) wr(4'(a), 8'hFF);
        for (int a = 13; a < 16; a++) wr(4'(a), 8'hFF);
        chk_outputs("R9 outputs after ro writes");
        read_all("R3/R4/R9 after ro writes");

        // R5 R6: each identifier byte, first write stored, second ignored
        do_reset();
        for (int i = 0; i < 4; i++) begin
            wr(4'(8 + i), 8'hA5 ^ 8'(i * 17));
            chk_outputs("R5 first write");
            wr(4'(8 + i), ~(8'hA5 ^ 8'(i * 17)));
            chk_outputs("R6 second write ignored");
        end
        read_all("R5 readback little-endian");

        // R10: reset reopens the locks
        do_reset();
        chk_outputs("R10 cleared");
        wr(4'hA, 8'h77); wr(4'hB, 8'h88);
        chk_outputs("R10 rewrite");
        chk("R10 ssid", {16'h0, ssid}, 32'h8877);

        // R7 R8: exhaustive capabilities sweep with noisy bits 7:5
        for (int v = 0; v < 32; v++) begin
            do_reset();
            wr(4'hC, {3'(v * 5 + 3), 5'(v)});
            chk("R8 bay count", {28'h0, bay_count},
                (v % 16 > 2) ? 32'd2 : 32'(v % 16));
            chk("R7 sec flag", {31'h0, sec_lock_present}, 32'(v / 16));
            rd_chk(4'hC, "R7 readback");
            wr(4'hC, ~8'(v));
            chk_outputs("R7 locked");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule